// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register Bank

This block keeps the machine-level interrupt enable, interrupt pending, interrupt delegation and exception delegation state of a processor hart. It also keeps the machine and supervisor trap vector bases, which support direct mode only. Software reaches all of it through one select, a write strobe, write data and a combinational read port. The two external interrupt lines drive their pending bits straight from hardware inputs.

The supervisor enable and pending registers have no storage of their own. Each is a window onto the machine register. The window is filtered by the interrupt delegation register, both when it is read and when it is written. A write to a vector register that asks for any mode other than direct is dropped, so the register keeps its old value.

Top module: `irq_deleg_regs`

## Requirements
- R1: `csr_sel` selects a register: 0 machine enable, 1 machine pending, 2 interrupt delegation, 3 exception delegation, 4 supervisor enable view, 5 supervisor pending view, 6 machine vector, 7 supervisor vector. `csr_rdata` shows the selected register in the same cycle. A write with `csr_we` high takes effect at the next rising clock edge. After reset every register reads zero, apart from the hardware-driven pending bits.
- R2: Only bits 1, 5 and 9 of the interrupt delegation register can be written. These are the supervisor software, timer and external interrupts. All other bits read zero.
- R3: Only bits 1, 3, 5, 7 and 9 of the machine enable register can be written. All other bits read zero.
- R4: A software write to the machine pending register changes only bits 1 and 5. Bit 9 reads `hw_seip` and bit 11 reads `hw_meip`. All other bits read zero.
- R5: The supervisor enable view reads as machine enable AND interrupt delegation. The supervisor pending view reads as machine pending AND interrupt delegation.
- R6: A write to the supervisor enable view changes only those machine enable bits that are set in the interrupt delegation register. Each such bit takes the written value.
- R7: A write to the supervisor pending view changes only the delegated bits among bits 1 and 5 of machine pending. A delegated bit 9 is not changed.
- R8: Only bits 0 to 9, 11, 12, 13 and 15 of the exception delegation register can be written. All other bits read zero.
- R9: A vector-register write whose bits [1:0] are 00 stores the value. A write with any other value in bits [1:0] leaves the register unchanged.
- R10: With `csr_we` low, no register changes, whatever the select and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | SELW | Register select (encoding in R1) |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected register, combinational |
| hw_meip | input | 1 | Machine external interrupt pending from hardware |
| hw_seip | input | 1 | Supervisor external interrupt pending from hardware |

## Verification
The register bank is driven with several kinds of write data:
- All-ones writes expose each write mask, because only the writable bits come back.
- Sparse patterns that set only non-writable bits show that those bits are dropped.
- Supervisor-view writes under different delegation values tell apart the bits that follow the window from the bits that keep their machine value.
- Toggling the two hardware lines separates the wired pending bits from the software bits.

Vector writes try all four mode encodings, so a stored direct value can be told apart from a rejected write.

// File: rtl/irq_deleg_regs.sv
`timescale 1ns/1ps
module irq_deleg_regs #(
  parameter int XLEN = 32,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] csr_sel,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            hw_meip,
  input  logic            hw_seip
);
  localparam logic [SELW-1:0] S_MIE = SELW'(0);
  localparam logic [SELW-1:0] S_MIP = SELW'(1);
  localparam logic [SELW-1:0] S_IDL = SELW'(2);
  localparam logic [SELW-1:0] S_EDL = SELW'(3);
  localparam logic [SELW-1:0] S_SIE = SELW'(4);
  localparam logic [SELW-1:0] S_SIP = SELW'(5);
  localparam logic [SELW-1:0] S_MTV = SELW'(6);
  localparam logic [SELW-1:0] S_STV = SELW'(7);

  localparam logic [XLEN-1:0] DELEG_MASK = XLEN'('h222);
  localparam logic [XLEN-1:0] EN_MASK    = XLEN'('h2AA);
  localparam logic [XLEN-1:0] SWP_MASK   = XLEN'('h022);
  localparam logic [XLEN-1:0] EXC_MASK   = XLEN'('hBBFF);

  logic [XLEN-1:0] mie_q, mip_sw_q, mideleg_q, medeleg_q, mtvec_q, stvec_q;
  logic [XLEN-1:0] pend, sie_next, sip_next;
  logic            direct_mode;

  assign pend        = mip_sw_q | (XLEN'(hw_seip) << 9) | (XLEN'(hw_meip) << 11);
  assign sie_next    = (mie_q & ~mideleg_q) | (csr_wdata & mideleg_q);
  assign sip_next    = (pend & ~mideleg_q) | (csr_wdata & mideleg_q);
  assign direct_mode = (csr_wdata[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mie_q     <= '0;
      mip_sw_q  <= '0;
      mideleg_q <= '0;
      medeleg_q <= '0;
      mtvec_q   <= '0;
      stvec_q   <= '0;
    end else if (csr_we) begin
      case (csr_sel)
        S_MIE: mie_q     <= (mie_q & ~EN_MASK) | (csr_wdata & EN_MASK);
        S_MIP: mip_sw_q  <= (mip_sw_q & ~SWP_MASK) | (csr_wdata & SWP_MASK);
        S_IDL: mideleg_q <= csr_wdata & DELEG_MASK;
        S_EDL: medeleg_q <= csr_wdata & EXC_MASK;
        S_SIE: mie_q     <= (mie_q & ~EN_MASK) | (sie_next & EN_MASK);
        S_SIP: mip_sw_q  <= (mip_sw_q & ~SWP_MASK) | (sip_next & SWP_MASK);
        S_MTV: if (direct_mode) mtvec_q <= csr_wdata;
        S_STV: if (direct_mode) stvec_q <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csr_sel)
      S_MIE:   csr_rdata = mie_q;
      S_MIP:   csr_rdata = pend;
      S_IDL:   csr_rdata = mideleg_q;
      S_EDL:   csr_rdata = medeleg_q;
      S_SIE:   csr_rdata = mie_q & mideleg_q;
      S_SIP:   csr_rdata = pend & mideleg_q;
      S_MTV:   csr_rdata = mtvec_q;
      S_STV:   csr_rdata = stvec_q;
      default: csr_rdata = '0;
    endcase
  end
endmodule

module irq_deleg_chk #(
  parameter int XLEN = 32,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SELW-1:0] csr_sel,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic            hw_meip,
  input logic            hw_seip,
  input logic [XLEN-1:0] mie_q,
  input logic [XLEN-1:0] mideleg_q,
  input logic [XLEN-1:0] medeleg_q,
  input logic [XLEN-1:0] mtvec_q
);
  a_r3_enable_mask: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> ((mie_q & ~XLEN'('h2AA)) == '0));

  a_r4_hw_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == SELW'(1)) |-> (csr_rdata[11] == hw_meip && csr_rdata[9] == hw_seip));

  a_r5_view_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == SELW'(4) || csr_sel == SELW'(5)) |-> ((csr_rdata & ~mideleg_q) == '0));

  a_r6_undelegated_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == SELW'(4)) |=> (((mie_q ^ $past(mie_q)) & ~$past(mideleg_q)) == '0));

  a_r9_mode_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == SELW'(6) && csr_wdata[1:0] != 2'b00) |=> $stable(mtvec_q));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ($stable(mie_q) && $stable(mideleg_q) && $stable(medeleg_q) && $stable(mtvec_q)));
endmodule

bind irq_deleg_regs irq_deleg_chk #(.XLEN(XLEN), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .hw_meip(hw_meip),
  .hw_seip(hw_seip), .mie_q(mie_q), .mideleg_q(mideleg_q),
  .medeleg_q(medeleg_q), .mtvec_q(mtvec_q)
);

// File: tb/sim_irq_deleg_regs.sv
`timescale 1ns/1ps
module sim_irq_deleg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  csr_sel = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        hw_meip = 1'b0, hw_seip = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_ie = 0, m_ip = 0, m_idl = 0, m_edl = 0, m_mtv = 0, m_stv = 0;

  irq_deleg_regs u0 (.clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .hw_meip(hw_meip), .hw_seip(hw_seip));

  always #5 clk = ~clk;

  function automatic logic [31:0] pend_m();
    return m_ip | (32'(hw_seip) << 9) | (32'(hw_meip) << 11);
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: return m_ie;
      3'd1: return pend_m();
      3'd2: return m_idl;
      3'd3: return m_edl;
      3'd4: return m_ie & m_idl;
      3'd5: return pend_m() & m_idl;
      3'd6: return m_mtv;
      default: return m_stv;
    endcase
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    logic [31:0] t;
    @(negedge clk);
    csr_sel = s; csr_wdata = d; csr_we = 1'b1;
    case (s)
      3'd0: m_ie  = d & 32'h2AA;
      3'd1: m_ip  = d & 32'h022;
      3'd2: m_idl = d & 32'h222;
      3'd3: m_edl = d & 32'hBBFF;
      3'd4: begin t = (m_ie & ~m_idl) | (d & m_idl); m_ie = t & 32'h2AA; end
      3'd5: begin t = (m_ip & ~m_idl) | (d & m_idl); m_ip = t & 32'h022; end
      3'd6: if (d[1:0] == 2'b00) m_mtv = d;
      default: if (d[1:0] == 2'b00) m_stv = d;
    endcase
    @(posedge clk); #1 csr_we = 1'b0;
  endtask

  task automatic chk(input logic [2:0] s, input string tag);
    @(negedge clk);
    csr_sel = s;
    exp_q.push_back(exp_read(s));
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (csr_rdata !== e) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", t, csr_sel, csr_rdata, e);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 8; i++) chk(3'(i), "R1");

    wr(3'd2, 32'hFFFF_FFFF); chk(3'd2, "R2");
    wr(3'd2, 32'hFFFF_FDDD); chk(3'd2, "R2");
    wr(3'd0, 32'hFFFF_FFFF); chk(3'd0, "R3");
    wr(3'd0, 32'hFFFF_FD55); chk(3'd0, "R3");

    wr(3'd1, 32'hFFFF_FFFF); chk(3'd1, "R4");
    @(negedge clk) hw_meip = 1'b1; chk(3'd1, "R4");
    @(negedge clk) hw_seip = 1'b1; chk(3'd1, "R4");
    wr(3'd1, 32'h0000_0000); chk(3'd1, "R4");

    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'h22);
    wr(3'd2, 32'h222); chk(3'd4, "R5"); chk(3'd5, "R5");
    wr(3'd2, 32'h020); chk(3'd4, "R5"); chk(3'd5, "R5");
    wr(3'd2, 32'h000); chk(3'd4, "R5"); chk(3'd5, "R5");

    wr(3'd0, 32'h0); wr(3'd2, 32'h020);
    wr(3'd4, 32'hFFFF_FFFF); chk(3'd0, "R6");
    wr(3'd0, 32'h2AA); wr(3'd2, 32'h002);
    wr(3'd4, 32'h0); chk(3'd0, "R6");
    wr(3'd2, 32'h222); wr(3'd4, 32'h0); chk(3'd0, "R6");

    wr(3'd1, 32'h0); wr(3'd2, 32'h222);
    wr(3'd5, 32'hFFFF_FFFF); chk(3'd1, "R7");
    wr(3'd2, 32'h200); wr(3'd1, 32'h0);
    @(negedge clk) hw_seip = 1'b0;
    wr(3'd5, 32'hFFFF_FFFF); chk(3'd1, "R7");
    wr(3'd2, 32'h002); wr(3'd5, 32'h0000_0022); chk(3'd1, "R7");

    wr(3'd3, 32'hFFFF_FFFF); chk(3'd3, "R8");
    wr(3'd3, 32'hFFFF_4400); chk(3'd3, "R8");

    wr(3'd6, 32'h0000_1000); chk(3'd6, "R9");
    wr(3'd6, 32'h0000_2001); chk(3'd6, "R9");
    wr(3'd6, 32'h0000_3002); chk(3'd6, "R9");
    wr(3'd6, 32'h0000_4003); chk(3'd6, "R9");
    wr(3'd7, 32'hFFFF_FFFC); chk(3'd7, "R9");
    wr(3'd7, 32'h0000_8001); chk(3'd7, "R9");

    wr(3'd2, 32'h222); wr(3'd0, 32'h2AA);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); csr_sel = 3'(i); csr_wdata = 32'h0;
      @(posedge clk);
    end
    for (int i = 0; i < 8; i++) chk(3'(i), "R10");

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule